// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block keeps a short queue of outstanding DRAM requests. Each request carries a bank number and a row number. Every cycle the block offers one queued request to the command stage. By default it prefers requests whose row is already open in their bank, because those requests need only a column command. Arrival order decides between requests that are equally ready. A mode pin changes the policy to plain oldest-first, and in that mode open-row state plays no part in the choice.

The queue collapses. Position 0 always holds the oldest request, and each higher position holds a younger one. When a request is granted, every younger entry moves down by one place, so the grant index is always the request's rank in arrival order. The command stage supplies, for each bank, whether a row is open and which row it is. The block tags every entry as a hit or a miss and reports the command kind the chosen entry needs.

Both data edges use valid/ready handshakes. A request is taken when `req_valid` and `req_ready` are both high. `req_ready` drops only when every slot is full, and it does not depend on a grant in the same cycle. A grant is consumed when `grant_valid` and `grant_ready` are both high. While `grant_ready` is low the offered request stays in the queue. The offer itself may change if the open-row inputs change.

Top module: `frfcfs_sched`

## Requirements
- R1: After reset the queue is empty, `grant_valid` is low and `req_ready` is high.
- R2: With the queue empty, `grant_valid` is low.
- R3: An entry is a hit when `open_valid[bank]` is set and `open_row` slice `bank` equals the entry's row. `grant_cmd` is 0 (column command) for a hit and 1 (row open/close command) for a miss.
- R4: With `fcfs_mode` low, if any queued entry hits, a hit entry is granted.
- R5: With `fcfs_mode` low and more than one hit entry queued, the oldest hit (lowest index) is granted.
- R6: With `fcfs_mode` low and no hit entry queued, the oldest entry (index 0) is granted.
- R7: With `fcfs_mode` high, index 0 is granted whatever the hit status, and `grant_cmd` still reports that entry's hit status.
- R8: `grant_idx` is the entry's position in arrival order, with 0 the oldest. `grant_bank` and `grant_row` are that entry's fields. A consumed grant removes the entry, and the younger entries each move down one position.
- R9: With all DEPTH slots occupied, `req_ready` is low and `req_valid` has no effect on the queue.
- R10: An enqueue and a consumed grant in the same cycle both take effect. The new request lands behind the surviving entries, and the occupancy stays the same.
- R11: While `grant_ready` is low, no entry is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 selects plain oldest-first |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A slot is free |
| req_bank | input | BANK_W | Bank of offered request |
| req_row | input | ROW_W | Row of offered request |
| open_valid | input | NBANK | Per-bank row-open flag |
| open_row | input | NBANK*ROW_W | Per-bank open row, bank b at bits [b*ROW_W +: ROW_W] |
| grant_valid | output | 1 | A request is offered for issue |
| grant_ready | input | 1 | Command stage takes the offer |
| grant_idx | output | IDX_W | Queue position of the offered request |
| grant_cmd | output | 1 | 0 column command, 1 row command |
| grant_bank | output | BANK_W | Bank of the offered request |
| grant_row | output | ROW_W | Row of the offered request |

## Verification
The case most likely to break is a grant consumed in the same cycle as an enqueue. The collapse of the younger entries and the write of the newcomer then target overlapping positions. The bench drives pseudo-random request and acceptance patterns at a queue depth of four, so this overlap occurs often. The overlap is provoked at each possible grant position and at each occupancy level. In the cycle after every such overlap, the bench compares the offered entry's bank and row, and its position, against an arithmetic queue model. Long stretches with `grant_ready` low fill the queue, so the full-queue case also coincides with grants.

// File: rtl/frfcfs_pkg.sv
package frfcfs_pkg;
  typedef enum logic {
    CMD_COL = 1'b0,
    CMD_ROW = 1'b1
  } cmd_kind_e;
endpackage

// File: rtl/sched_queue.sv
// Collapsing request store: position 0 is always the oldest entry.
module sched_queue #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enq_fire,
  input  logic [BANK_W-1:0]             enq_bank,
  input  logic [ROW_W-1:0]              enq_row,
  input  logic                          deq_fire,
  input  logic [IDX_W-1:0]              deq_idx,
  output logic [DEPTH-1:0]              ent_valid,
  output logic [DEPTH-1:0][BANK_W-1:0]  ent_bank,
  output logic [DEPTH-1:0][ROW_W-1:0]   ent_row,
  output logic [CNT_W-1:0]              count,
  output logic                          full
);
  logic [DEPTH-1:0][BANK_W-1:0] bank_q, bank_n;
  logic [DEPTH-1:0][ROW_W-1:0]  row_q, row_n;
  logic [CNT_W-1:0]             cnt_q, cnt_n, wr_pos;

  always_comb begin
    bank_n = bank_q;
    row_n  = row_q;
    for (int p = 0; p < DEPTH - 1; p++) begin
      if (deq_fire && p >= int'(deq_idx)) begin
        bank_n[p] = bank_q[p+1];
        row_n[p]  = row_q[p+1];
      end
    end
    wr_pos = cnt_q - CNT_W'(deq_fire);
    if (enq_fire) begin
      bank_n[wr_pos[IDX_W-1:0]] = enq_bank;
      row_n[wr_pos[IDX_W-1:0]]  = enq_row;
    end
    cnt_n = cnt_q + CNT_W'(enq_fire) - CNT_W'(deq_fire);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      cnt_q  <= '0;
    end else begin
      bank_q <= bank_n;
      row_q  <= row_n;
      cnt_q  <= cnt_n;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_vld
      assign ent_valid[g] = (CNT_W'(g) < cnt_q);
    end
  endgenerate

  assign ent_bank = bank_q;
  assign ent_row  = row_q;
  assign count    = cnt_q;
  assign full     = (cnt_q == CNT_W'(DEPTH));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r8_drop_one: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_fire && !enq_fire) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r10_swap_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_fire && enq_fire) |=> cnt_q == $past(cnt_q));
  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!deq_fire && !enq_fire) |=> ($stable(cnt_q) && $stable(bank_q) && $stable(row_q)));
endmodule

// File: rtl/hit_detect.sv
// Per-entry comparison against the open row of the entry's bank.
module hit_detect #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 4,
  parameter int ROW_W  = 8,
  localparam int BANK_W = $clog2(NBANK)
) (
  input  logic [DEPTH-1:0]              ent_valid,
  input  logic [DEPTH-1:0][BANK_W-1:0]  ent_bank,
  input  logic [DEPTH-1:0][ROW_W-1:0]   ent_row,
  input  logic [NBANK-1:0]              open_valid,
  input  logic [NBANK-1:0][ROW_W-1:0]   open_row,
  output logic [DEPTH-1:0]              hit
);
  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_cmp
      logic [BANK_W-1:0] bsel;
      assign bsel   = ent_bank[i];
      assign hit[i] = ent_valid[i] && (int'(bsel) < NBANK) &&
                      open_valid[bsel] && (open_row[bsel] == ent_row[i]);
    end
  endgenerate
endmodule

// File: rtl/oldest_pick.sv
// Lowest set index wins; in the collapsing queue lower index means older.
module oldest_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/frfcfs_sched.sv
module frfcfs_sched
  import frfcfs_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int NBANK = 4,
  parameter int ROW_W = 8,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fcfs_mode,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ROW_W-1:0]        req_row,
  input  logic [NBANK-1:0]        open_valid,
  input  logic [NBANK*ROW_W-1:0]  open_row,
  output logic                    grant_valid,
  input  logic                    grant_ready,
  output logic [IDX_W-1:0]        grant_idx,
  output logic                    grant_cmd,
  output logic [BANK_W-1:0]       grant_bank,
  output logic [ROW_W-1:0]        grant_row
);
  logic [DEPTH-1:0]             ent_valid, hit;
  logic [DEPTH-1:0][BANK_W-1:0] ent_bank;
  logic [DEPTH-1:0][ROW_W-1:0]  ent_row;
  logic [NBANK-1:0][ROW_W-1:0]  open_row_a;
  logic [CNT_W-1:0]             count;
  logic                         full, enq_fire, deq_fire;
  logic                         hit_found, any_found, use_hit;
  logic [IDX_W-1:0]             hit_idx, any_idx;

  assign open_row_a = open_row;
  assign req_ready  = !full;
  assign enq_fire   = req_valid && req_ready;
  assign deq_fire   = grant_valid && grant_ready;

  sched_queue #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .enq_fire(enq_fire), .enq_bank(req_bank), .enq_row(req_row),
    .deq_fire(deq_fire), .deq_idx(grant_idx),
    .ent_valid(ent_valid), .ent_bank(ent_bank), .ent_row(ent_row),
    .count(count), .full(full)
  );

  hit_detect #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W)) u_hit (
    .ent_valid(ent_valid), .ent_bank(ent_bank), .ent_row(ent_row),
    .open_valid(open_valid), .open_row(open_row_a), .hit(hit)
  );

  oldest_pick #(.N(DEPTH)) u_pick_hit (.req(hit), .found(hit_found), .idx(hit_idx));
  oldest_pick #(.N(DEPTH)) u_pick_any (.req(ent_valid), .found(any_found), .idx(any_idx));

  assign use_hit     = !fcfs_mode && hit_found;
  assign grant_valid = any_found;
  assign grant_idx   = use_hit ? hit_idx : any_idx;
  assign grant_cmd   = hit[grant_idx] ? logic'(CMD_COL) : logic'(CMD_ROW);
  assign grant_bank  = ent_bank[grant_idx];
  assign grant_row   = ent_row[grant_idx];

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !grant_valid);
  a_r4_hits_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !fcfs_mode && (|hit)) |-> grant_cmd == logic'(CMD_COL));
  a_r6_miss_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !(|hit)) |-> grant_idx == '0);
  a_r7_fcfs_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && fcfs_mode) |-> grant_idx == '0);
  a_r9_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_W'(DEPTH)) |-> !req_ready);
endmodule

// File: tb/frfcfs_sched_tb.sv
module frfcfs_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 4;
  localparam int NB = 2;
  localparam int RW = 2;
  localparam int NCYC = 6000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcfs_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [0:0] req_bank = '0;
  logic [RW-1:0] req_row = '0;
  logic [NB-1:0] open_valid = '0;
  logic [NB*RW-1:0] open_row = '0;
  logic grant_valid;
  logic grant_ready = 1'b0;
  logic [1:0] grant_idx;
  logic grant_cmd;
  logic [0:0] grant_bank;
  logic [RW-1:0] grant_row;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frfcfs_sched #(.DEPTH(D), .NBANK(NB), .ROW_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fcfs_mode(fcfs_mode),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row),
    .open_valid(open_valid), .open_row(open_row),
    .grant_valid(grant_valid), .grant_ready(grant_ready),
    .grant_idx(grant_idx), .grant_cmd(grant_cmd),
    .grant_bank(grant_bank), .grant_row(grant_row)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // arithmetic queue model
  int mb[D];
  int mr[D];
  int mcnt = 0;

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    bit prev_swap = 1'b0;
    bit prev_stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 grant_valid after reset", int'(grant_valid), 0);
    chk("R1 req_ready after reset", int'(req_ready), 1);

    for (int cyc = 0; cyc < NCYC; cyc++) begin
      int ov[NB];
      int orw[NB];
      int hits[D];
      int nhit, exp_idx, anyv, deq, enq;
      string itag;
      @(negedge clk);
      for (int s = 0; s < 4; s++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      fcfs_mode   = ((cyc / 700) % 3) == 2;
      req_valid   = (lfsr[1:0] != 2'b00);
      req_bank    = lfsr[2];
      req_row     = lfsr[4:3];
      open_valid  = lfsr[6:5];
      open_row    = lfsr[10:7];
      grant_ready = ((cyc % 80) < 20) ? 1'b0 : lfsr[11];
      for (int b = 0; b < NB; b++) begin
        ov[b]  = int'(open_valid[b]);
        orw[b] = int'(open_row[b*RW +: RW]);
      end
      #1;
      nhit = 0;
      exp_idx = -1;
      for (int i = 0; i < mcnt; i++) begin
        hits[i] = (ov[mb[i]] != 0 && orw[mb[i]] == mr[i]) ? 1 : 0;
        if (hits[i] != 0) begin
          if (exp_idx < 0 && !fcfs_mode) exp_idx = i;
          nhit++;
        end
      end
      anyv = (mcnt > 0) ? 1 : 0;
      if (exp_idx < 0 && anyv != 0) exp_idx = 0;

      chk("R9 req_ready vs occupancy", int'(req_ready), (mcnt < D) ? 1 : 0);
      chk(anyv != 0 ? "R8 grant_valid with entries" : "R2 grant_valid when empty",
          int'(grant_valid), anyv);
      if (anyv != 0 && grant_valid) begin
        if (fcfs_mode)      itag = "R7 fcfs oldest";
        else if (nhit > 1)  itag = "R5 oldest hit";
        else if (nhit == 1) itag = "R4 hit first";
        else                itag = "R6 oldest miss";
        chk(itag, int'(grant_idx), exp_idx);
        chk("R3 command kind", int'(grant_cmd), hits[exp_idx] != 0 ? 0 : 1);
        itag = prev_swap ? "R10 content after enq+deq" :
               prev_stall ? "R11 content after stall" : "R8 content bank";
        chk(itag, int'(grant_bank), mb[exp_idx]);
        chk("R8 content row", int'(grant_row), mr[exp_idx]);
      end

      deq = (anyv != 0 && grant_ready) ? 1 : 0;
      enq = (req_valid && mcnt < D) ? 1 : 0;
      prev_stall = (anyv != 0 && !grant_ready);
      prev_swap  = (deq != 0 && enq != 0);
      if (deq != 0) begin
        for (int p = exp_idx; p < D - 1; p++) begin
          mb[p] = mb[p+1];
          mr[p] = mr[p+1];
        end
        mcnt--;
      end
      if (enq != 0) begin
        mb[mcnt] = int'(req_bank);
        mr[mcnt] = int'(req_row);
        mcnt++;
      end
    end

    @(negedge clk);
    req_valid = 1'b0;
    grant_ready = 1'b1;
    repeat (D + 1) @(negedge clk);
    #1;
    chk("R2 drained queue idle", int'(grant_valid), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule